// File: doc/BRIEF.md
# Packet-Train Frame Generator

This block sends a train of identical UDP-over-IPv4 Ethernet frames on an AXI4-Stream master port. The frames leave back-to-back, with no idle cycle between them, so that a receiver can measure how far the train spreads on its way through the network. Configuration inputs set both MAC addresses, both IPv4 addresses, both UDP ports, the frame length (preamble and FCS not included) and the number of frames in the train. A one-cycle start pulse launches the train. The block builds each frame on the fly from the captured settings. It inserts a 32-bit sequence number that counts up from zero and a 64-bit transmit time that it reads from a free-running time input on the cycle the frame's first beat is accepted.

The control is a three-state machine: IDLE (no train), HEAD (the first beat of a frame is offered) and BODY (the remaining beats). The transitions are named *launch* (IDLE to HEAD, on an accepted start), *advance* (HEAD to BODY, when the first beat is accepted), *chain* (BODY to HEAD, or HEAD to HEAD for a one-beat frame, when the last beat is accepted and frames remain) and *finish* (to IDLE, when the last beat of the final frame is accepted). The stream width is a parameter. The same logic serves a 32-bit and a 256-bit data path.

Top module: `pkt_train_gen`

## Requirements
- R1: After reset, `busy`, `m_tvalid` and `m_tlast` are low.
- R2: A start pulse seen while idle, with a nonzero train length N, raises `busy` one cycle later. Exactly N frames are emitted. `busy` falls on the cycle after the last beat of frame N is accepted.
- R3: A start pulse while `busy` is high has no effect. A start pulse with a train length of zero leaves `busy` low.
- R4: Bytes travel in network order, with frame byte k on lane k mod W/8 (bits 8*lane+7:8*lane) of beat k div W/8. The frame starts with a 14-byte Ethernet header: destination MAC, source MAC, then ethertype 0x0800. A 20-byte IPv4 header follows (0x45, TOS 0, total length, ID 0, flags 0x4000, TTL 64, protocol 17, checksum, source IP, destination IP). An 8-byte UDP header follows (source port, destination port, length, checksum).
- R5: The IPv4 total length is L-14 and the UDP length is L-34. The IPv4 checksum at bytes 24-25 is the ones'-complement of the ones'-complement sum of the header's ten 16-bit words. The UDP checksum is zero.
- R6: Bytes 42-45 carry the sequence number, most significant byte first. It is 0 in the first frame of every train and increases by one per frame.
- R7: Bytes 46-53 carry `time_in`, most significant byte first, as sampled on the cycle the frame's first beat is accepted. Every payload byte from offset 54 to the end of the frame is zero.
- R8: While `busy` is high, `m_tvalid` is high on every cycle. The first beat of the next frame is offered on the cycle after the previous `m_tlast` beat is accepted.
- R9: While `m_tvalid` is high and `m_tready` is low, `m_tdata`, `m_tkeep` and `m_tlast` hold their values.
- R10: A frame takes ceil(L/(W/8)) beats. `m_tlast` marks the final beat. `m_tkeep` is all ones on other beats and has exactly the low L mod (W/8) lanes set on the final beat (all lanes when that remainder is zero).
- R11: The frame length L is the configured length clamped to the range 60 to 1514 bytes.
- R12: All configuration inputs are captured by the accepted start pulse. Later changes have no effect on the train in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_dst_mac | input | 48 | Destination MAC address |
| cfg_src_mac | input | 48 | Source MAC address |
| cfg_src_ip | input | 32 | Source IPv4 address |
| cfg_dst_ip | input | 32 | Destination IPv4 address |
| cfg_src_port | input | 16 | UDP source port |
| cfg_dst_port | input | 16 | UDP destination port |
| cfg_frame_len | input | 11 | Frame length in bytes, before clamping |
| cfg_train_len | input | CNT_W (16) | Number of frames in the train |
| start | input | 1 | One-cycle start pulse |
| time_in | input | 64 | Free-running time value |
| m_tdata | output | DATA_W (32) | Stream data |
| m_tkeep | output | DATA_W/8 (4) | Byte enables |
| m_tvalid | output | 1 | Stream valid |
| m_tlast | output | 1 | Final beat of a frame |
| m_tready | input | 1 | Stream ready from the sink |
| busy | output | 1 | A train is in progress |

## Verification
The bench builds the block with the default parameters: a 32-bit stream (four lanes), a 16-bit train counter and the 60 to 1514 clamp. With four lanes, the frame lengths 60, 61, 62 and 63 cover every final-beat `m_tkeep` pattern. Header fields, the sequence number and the timestamp all cross beat boundaries, which exercises the lane mapping of R4. A long train of 100 frames under random backpressure tests the back-to-back chaining, the stall hold and the sequence restart. Out-of-range lengths test both ends of the clamp.

// File: rtl/pt_pkg.sv
package pt_pkg;

    localparam int LEN_W  = 11;
    localparam int OFF_W  = 12;
    localparam int SEQ_W  = 32;
    localparam int TS_W   = 64;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_HEAD,
        ST_BODY
    } pt_state_e;

    typedef struct packed {
        logic [47:0]      dst_mac;
        logic [47:0]      src_mac;
        logic [31:0]      src_ip;
        logic [31:0]      dst_ip;
        logic [15:0]      src_port;
        logic [15:0]      dst_port;
        logic [LEN_W-1:0] frame_len;
    } pt_cfg_t;

    // Byte of the frame at offset off (network order).
    function automatic logic [7:0] pt_frame_byte(
        input logic [OFF_W-1:0] off,
        input pt_cfg_t          c,
        input logic [15:0]      csum,
        input logic [SEQ_W-1:0] seq,
        input logic [TS_W-1:0]  ts
    );
        int          k;
        logic [15:0] ip_len;
        logic [15:0] udp_len;
        logic [7:0]  b;
        k       = int'(off);
        ip_len  = 16'(c.frame_len) - 16'd14;
        udp_len = 16'(c.frame_len) - 16'd34;
        b       = 8'h00;
        if (k < 6)        b = c.dst_mac[8*(5-k) +: 8];
        else if (k < 12)  b = c.src_mac[8*(11-k) +: 8];
        else if (k == 12) b = 8'h08;
        else if (k == 14) b = 8'h45;
        else if (k == 16) b = ip_len[15:8];
        else if (k == 17) b = ip_len[7:0];
        else if (k == 20) b = 8'h40;
        else if (k == 22) b = 8'h40;
        else if (k == 23) b = 8'h11;
        else if (k == 24) b = csum[15:8];
        else if (k == 25) b = csum[7:0];
        else if (k >= 26 && k < 30) b = c.src_ip[8*(29-k) +: 8];
        else if (k >= 30 && k < 34) b = c.dst_ip[8*(33-k) +: 8];
        else if (k == 34) b = c.src_port[15:8];
        else if (k == 35) b = c.src_port[7:0];
        else if (k == 36) b = c.dst_port[15:8];
        else if (k == 37) b = c.dst_port[7:0];
        else if (k == 38) b = udp_len[15:8];
        else if (k == 39) b = udp_len[7:0];
        else if (k >= 42 && k < 46) b = seq[8*(45-k) +: 8];
        else if (k >= 46 && k < 54) b = ts[8*(53-k) +: 8];
        return b;
    endfunction

endpackage

// File: rtl/pt_ipv4_csum.sv
module pt_ipv4_csum
    import pt_pkg::*;
(
    input  logic [LEN_W-1:0] frame_len,
    input  logic [31:0]      src_ip,
    input  logic [31:0]      dst_ip,
    output logic [15:0]      csum
);
    logic [15:0] ip_len;
    logic [19:0] acc;
    logic [16:0] fold1;
    logic [15:0] fold2;

    always_comb begin
        ip_len = 16'(frame_len) - 16'd14;
        acc    = 20'h04500 + 20'(ip_len) + 20'h04000 + 20'h04011
               + 20'(src_ip[31:16]) + 20'(src_ip[15:0])
               + 20'(dst_ip[31:16]) + 20'(dst_ip[15:0]);
        fold1  = 17'(acc[15:0]) + 17'(acc[19:16]);
        fold2  = fold1[15:0] + 16'(fold1[16]);
        csum   = ~fold2;
    end
endmodule

// File: rtl/pt_beat_fmt.sv
module pt_beat_fmt
    import pt_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int BEAT_W = 9,
    localparam int BYTES = DATA_W / 8
) (
    input  pt_cfg_t           cfg,
    input  logic [15:0]       csum,
    input  logic [SEQ_W-1:0]  seq,
    input  logic [TS_W-1:0]   ts,
    input  logic [BEAT_W-1:0] beat_idx,
    input  logic              last,
    output logic [DATA_W-1:0] tdata,
    output logic [BYTES-1:0]  tkeep
);
    for (genvar l = 0; l < BYTES; l++) begin : g_lane
        logic [OFF_W-1:0] off;
        assign off = OFF_W'(beat_idx) * OFF_W'(BYTES) + OFF_W'(l);
        assign tdata[8*l +: 8] = pt_frame_byte(off, cfg, csum, seq, ts);
        assign tkeep[l] = !last || (off < OFF_W'(cfg.frame_len));
    end
endmodule

// File: rtl/pt_train_ctl.sv
module pt_train_ctl
    import pt_pkg::*;
#(
    parameter int BYTES  = 4,
    parameter int BEAT_W = 9,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [CNT_W-1:0]  train_len,
    input  logic [LEN_W-1:0]  frame_len,
    input  logic              tready,
    output logic              busy,
    output logic              tvalid,
    output logic              tlast,
    output logic              head,
    output logic              load_cfg,
    output logic [BEAT_W-1:0] beat_idx,
    output logic [SEQ_W-1:0]  seq
);
    pt_state_e        state_q, state_d;
    logic [BEAT_W-1:0] beat_q;
    logic [CNT_W-1:0]  left_q;
    logic [SEQ_W-1:0]  seq_q;
    logic [OFF_W-1:0]  beat_end;
    logic              last_beat;
    logic              fire;
    logic              start_ok;

    assign beat_end  = (OFF_W'(beat_q) + OFF_W'(1)) * OFF_W'(BYTES);
    assign last_beat = beat_end >= OFF_W'(frame_len);
    assign start_ok  = start && (state_q == ST_IDLE) && (train_len != '0);
    assign fire      = tvalid && tready;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state: launch, advance, chain, finish
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start_ok) state_d = ST_HEAD;
            ST_HEAD: if (fire) begin
                if (!last_beat)         state_d = ST_BODY;
                else if (left_q == '0)  state_d = ST_IDLE;
                else                    state_d = ST_HEAD;
            end
            ST_BODY: if (fire && last_beat) begin
                if (left_q == '0) state_d = ST_IDLE;
                else              state_d = ST_HEAD;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // beat, frame and sequence counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            beat_q <= '0;
            left_q <= '0;
            seq_q  <= '0;
        end else if (start_ok) begin
            beat_q <= '0;
            left_q <= train_len - CNT_W'(1);
            seq_q  <= '0;
        end else if (fire) begin
            if (last_beat) begin
                beat_q <= '0;
                if (left_q != '0) begin
                    left_q <= left_q - CNT_W'(1);
                    seq_q  <= seq_q + SEQ_W'(1);
                end
            end else begin
                beat_q <= beat_q + BEAT_W'(1);
            end
        end
    end

    // outputs
    always_comb begin
        busy     = (state_q != ST_IDLE);
        tvalid   = busy;
        tlast    = busy && last_beat;
        head     = (state_q == ST_HEAD);
        load_cfg = start_ok;
        beat_idx = beat_q;
        seq      = seq_q;
    end
endmodule

// File: rtl/pkt_train_gen.sv
module pkt_train_gen
    import pt_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int CNT_W   = 16,
    parameter int MIN_LEN = 60,
    parameter int MAX_LEN = 1514,
    localparam int BYTES  = DATA_W / 8,
    localparam int BEAT_W = $clog2((MAX_LEN + BYTES - 1) / BYTES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [47:0]       cfg_dst_mac,
    input  logic [47:0]       cfg_src_mac,
    input  logic [31:0]       cfg_src_ip,
    input  logic [31:0]       cfg_dst_ip,
    input  logic [15:0]       cfg_src_port,
    input  logic [15:0]       cfg_dst_port,
    input  logic [10:0]       cfg_frame_len,
    input  logic [CNT_W-1:0]  cfg_train_len,
    input  logic              start,
    input  logic [63:0]       time_in,
    output logic [DATA_W-1:0] m_tdata,
    output logic [BYTES-1:0]  m_tkeep,
    output logic              m_tvalid,
    output logic              m_tlast,
    input  logic              m_tready,
    output logic              busy
);
    pt_cfg_t           cfg_q;
    logic [TS_W-1:0]   ts_q;
    logic [TS_W-1:0]   ts_use;
    logic [15:0]       csum;
    logic              head;
    logic              load_cfg;
    logic [BEAT_W-1:0] beat_idx;
    logic [SEQ_W-1:0]  seq;
    logic [LEN_W-1:0]  len_clamped;

    always_comb begin
        if (cfg_frame_len < LEN_W'(MIN_LEN))      len_clamped = LEN_W'(MIN_LEN);
        else if (cfg_frame_len > LEN_W'(MAX_LEN)) len_clamped = LEN_W'(MAX_LEN);
        else                                      len_clamped = cfg_frame_len;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (load_cfg) begin
            cfg_q.dst_mac   <= cfg_dst_mac;
            cfg_q.src_mac   <= cfg_src_mac;
            cfg_q.src_ip    <= cfg_src_ip;
            cfg_q.dst_ip    <= cfg_dst_ip;
            cfg_q.src_port  <= cfg_src_port;
            cfg_q.dst_port  <= cfg_dst_port;
            cfg_q.frame_len <= len_clamped;
        end
    end

    // transmit time captured when the first beat leaves
    always_ff @(posedge clk) begin
        if (!rst_n)                        ts_q <= '0;
        else if (head && m_tvalid && m_tready) ts_q <= time_in;
    end

    assign ts_use = head ? time_in : ts_q;

    pt_train_ctl #(.BYTES(BYTES), .BEAT_W(BEAT_W), .CNT_W(CNT_W)) u_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .train_len (cfg_train_len),
        .frame_len (cfg_q.frame_len),
        .tready    (m_tready),
        .busy      (busy),
        .tvalid    (m_tvalid),
        .tlast     (m_tlast),
        .head      (head),
        .load_cfg  (load_cfg),
        .beat_idx  (beat_idx),
        .seq       (seq)
    );

    pt_ipv4_csum u_csum (
        .frame_len (cfg_q.frame_len),
        .src_ip    (cfg_q.src_ip),
        .dst_ip    (cfg_q.dst_ip),
        .csum      (csum)
    );

    pt_beat_fmt #(.DATA_W(DATA_W), .BEAT_W(BEAT_W)) u_fmt (
        .cfg      (cfg_q),
        .csum     (csum),
        .seq      (seq),
        .ts       (ts_use),
        .beat_idx (beat_idx),
        .last     (m_tlast),
        .tdata    (m_tdata),
        .tkeep    (m_tkeep)
    );
endmodule

// File: rtl/pkt_train_gen_chk.sv
module pkt_train_gen_chk #(
    parameter int DATA_W = 32
) (
    input logic                clk,
    input logic                rst_n,
    input logic                start,
    input logic                busy,
    input logic                m_tvalid,
    input logic                m_tready,
    input logic                m_tlast,
    input logic [DATA_W-1:0]   m_tdata,
    input logic [DATA_W/8-1:0] m_tkeep
);
    // R9
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (m_tvalid && !m_tready) |=> (m_tvalid && $stable(m_tdata) && $stable(m_tkeep) && $stable(m_tlast)));

    // R8
    gapless_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> m_tvalid);

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!m_tvalid && !m_tlast));

    // R10
    full_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (m_tvalid && !m_tlast) |-> (&m_tkeep));

    // R10
    tail_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        m_tlast |-> m_tkeep[0]);

    // R2
    busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(m_tvalid && m_tready && m_tlast));

    // R2
    busy_begin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));

    // R3
    no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && !(m_tvalid && m_tready && m_tlast)) |=> busy);
endmodule

bind pkt_train_gen pkt_train_gen_chk #(.DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .busy     (busy),
    .m_tvalid (m_tvalid),
    .m_tready (m_tready),
    .m_tlast  (m_tlast),
    .m_tdata  (m_tdata),
    .m_tkeep  (m_tkeep)
);

// File: tb/pkt_train_gen_test.sv
module pkt_train_gen_test;
    localparam int DW = 32;
    localparam int NB = DW / 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [47:0]   cfg_dst_mac = '0, cfg_src_mac = '0;
    logic [31:0]   cfg_src_ip = '0, cfg_dst_ip = '0;
    logic [15:0]   cfg_src_port = '0, cfg_dst_port = '0;
    logic [10:0]   cfg_frame_len = 11'd60;
    logic [15:0]   cfg_train_len = '0;
    logic          start = 1'b0;
    logic [63:0]   time_now = 64'h1122_3344_5566_7700;
    logic [DW-1:0] m_tdata;
    logic [NB-1:0] m_tkeep;
    logic          m_tvalid, m_tlast, busy;
    logic          m_tready = 1'b1;

    int  checks = 0;
    int  errors = 0;
    bit  done = 0;
    bit  rnd_ready = 0;

    always #2 clk = ~clk;

    always @(posedge clk) time_now <= time_now + 64'd1;

    always @(posedge clk) begin
        #1;
        m_tready = rnd_ready ? (($urandom % 4) != 0) : 1'b1;
    end

    pkt_train_gen uut (
        .clk(clk), .rst_n(rst_n),
        .cfg_dst_mac(cfg_dst_mac), .cfg_src_mac(cfg_src_mac),
        .cfg_src_ip(cfg_src_ip), .cfg_dst_ip(cfg_dst_ip),
        .cfg_src_port(cfg_src_port), .cfg_dst_port(cfg_dst_port),
        .cfg_frame_len(cfg_frame_len), .cfg_train_len(cfg_train_len),
        .start(start), .time_in(time_now),
        .m_tdata(m_tdata), .m_tkeep(m_tkeep), .m_tvalid(m_tvalid),
        .m_tlast(m_tlast), .m_tready(m_tready), .busy(busy)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // reference model state
    bit          m_busy = 0;
    int          m_left, m_seq, m_beat, m_len, m_frames, m_bytes;
    logic [47:0] l_dmac, l_smac;
    logic [31:0] l_sip, l_dip;
    logic [15:0] l_sport, l_dport;
    logic [7:0]  fb [0:2047];
    bit          prev_stall = 0;
    logic [DW-1:0] prev_data;
    logic [NB-1:0] prev_keep;
    logic          prev_last;

    task automatic build_frame(input logic [63:0] ts);
        int s;
        for (int i = 0; i < 2048; i++) fb[i] = 8'h00;
        for (int i = 0; i < 6; i++) begin
            fb[i]     = l_dmac[8*(5-i) +: 8];
            fb[6+i]   = l_smac[8*(5-i) +: 8];
        end
        fb[12] = 8'h08; fb[14] = 8'h45;
        fb[16] = 8'((m_len - 14) >> 8); fb[17] = 8'(m_len - 14);
        fb[20] = 8'h40; fb[22] = 8'h40; fb[23] = 8'h11;
        for (int i = 0; i < 4; i++) begin
            fb[26+i] = l_sip[8*(3-i) +: 8];
            fb[30+i] = l_dip[8*(3-i) +: 8];
            fb[42+i] = 8'(m_seq >> (8*(3-i)));
        end
        fb[34] = l_sport[15:8]; fb[35] = l_sport[7:0];
        fb[36] = l_dport[15:8]; fb[37] = l_dport[7:0];
        fb[38] = 8'((m_len - 34) >> 8); fb[39] = 8'(m_len - 34);
        for (int i = 0; i < 8; i++) fb[46+i] = ts[8*(7-i) +: 8];
        s = 0;
        for (int i = 14; i < 34; i += 2) s += {fb[i], fb[i+1]};
        while ((s >> 16) != 0) s = (s & 32'hFFFF) + (s >> 16);
        s = ~s;
        fb[24] = 8'(s >> 8); fb[25] = 8'(s);
    endtask

    function automatic string tag_of(input int off);
        if (off >= 42 && off < 46) return "R6";
        if (off >= 46) return "R7";
        if (off >= 24 && off < 26) return "R5";
        if ((off >= 16 && off < 18) || (off >= 38 && off < 42)) return "R5";
        return "R4";
    endfunction

    always @(negedge clk) begin
        if (rst_n && !done) begin
            bit was_busy;
            was_busy = m_busy;
            check(busy == m_busy, "R2", "busy vs model", longint'(busy), longint'(m_busy));
            check(m_tvalid == m_busy, "R8", "tvalid while train active", longint'(m_tvalid), longint'(m_busy));
            if (prev_stall) begin
                check(m_tdata == prev_data && m_tkeep == prev_keep && m_tlast == prev_last,
                      "R9", "beat held under stall", longint'(m_tdata), longint'(prev_data));
            end
            prev_stall = m_tvalid && !m_tready;
            prev_data = m_tdata; prev_keep = m_tkeep; prev_last = m_tlast;
            if (m_tvalid && m_tready && m_busy) begin
                bit exp_last;
                logic [NB-1:0] exp_keep;
                if (m_beat == 0) begin
                    build_frame(time_now);
                    m_bytes = 0;
                end
                exp_last = ((m_beat + 1) * NB) >= m_len;
                for (int l = 0; l < NB; l++) exp_keep[l] = (m_beat * NB + l) < m_len;
                check(m_tlast == exp_last, "R10", "tlast", longint'(m_tlast), longint'(exp_last));
                check(m_tkeep == exp_keep, "R10", "tkeep", longint'(m_tkeep), longint'(exp_keep));
                for (int l = 0; l < NB; l++) begin
                    int off;
                    off = m_beat * NB + l;
                    if (off < m_len) begin
                        check(m_tdata[8*l +: 8] == fb[off], tag_of(off), $sformatf("byte %0d", off),
                              longint'(m_tdata[8*l +: 8]), longint'(fb[off]));
                    end
                end
                m_bytes += $countones(m_tkeep);
                m_beat++;
                if (exp_last) begin
                    check(m_bytes == m_len, "R11", "frame byte count", longint'(m_bytes), longint'(m_len));
                    m_beat = 0;
                    m_seq++;
                    m_frames++;
                    m_left--;
                    if (m_left == 0) m_busy = 0;
                end
            end
            if (start && !was_busy && cfg_train_len != 0) begin
                m_busy = 1; m_left = int'(cfg_train_len); m_seq = 0; m_beat = 0; m_frames = 0;
                m_len = (cfg_frame_len < 60) ? 60 : (cfg_frame_len > 1514) ? 1514 : int'(cfg_frame_len);
                l_dmac = cfg_dst_mac; l_smac = cfg_src_mac; l_sip = cfg_src_ip; l_dip = cfg_dst_ip;
                l_sport = cfg_src_port; l_dport = cfg_dst_port;
            end
        end
    end

    task automatic pulse_start();
        @(posedge clk); #1 start = 1'b1;
        @(posedge clk); #1 start = 1'b0;
    endtask

    task automatic run_train(input int len, input int n, input bit rnd);
        rnd_ready = rnd;
        cfg_frame_len = 11'(len);
        cfg_train_len = 16'(n);
        pulse_start();
        @(negedge clk);
        while (m_busy) @(negedge clk);
        check(m_frames == n, "R2", "frames in train", longint'(m_frames), longint'(n));
        repeat (2) @(negedge clk);
    endtask

    task automatic finish_run();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        cfg_dst_mac = 48'h0A1B_2C3D_4E5F; cfg_src_mac = 48'h6172_8394_A5B6;
        cfg_src_ip = 32'hC0A8_0101; cfg_dst_ip = 32'h0A00_00FE;
        cfg_src_port = 16'h1234; cfg_dst_port = 16'hBEEF;
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(busy == 0, "R1", "busy after reset", longint'(busy), 0);
        check(m_tvalid == 0, "R1", "tvalid after reset", longint'(m_tvalid), 0);
        check(m_tlast == 0, "R1", "tlast after reset", longint'(m_tlast), 0);

        run_train(60, 3, 0);
        run_train(61, 2, 1);
        run_train(62, 2, 1);
        run_train(63, 2, 0);
        run_train(30, 1, 0);    // R11 low clamp
        run_train(2000, 2, 1);  // R11 high clamp

        // R3 and R12: restart attempt and config change mid-train
        rnd_ready = 1;
        cfg_frame_len = 11'd128; cfg_train_len = 16'd5;
        pulse_start();
        repeat (40) @(posedge clk);
        #1;
        cfg_src_ip = 32'hDEAD_BEEF; cfg_frame_len = 11'd200; cfg_train_len = 16'd9;
        cfg_dst_port = 16'h0001;
        pulse_start();
        @(negedge clk);
        while (m_busy) @(negedge clk);
        check(m_frames == 5, "R3", "start while busy ignored", longint'(m_frames), 5);
        repeat (2) @(negedge clk);

        // R3 zero-length train
        cfg_train_len = 16'd0;
        pulse_start();
        repeat (4) @(negedge clk);
        check(busy == 0, "R3", "zero train length leaves idle", longint'(busy), 0);

        // R6 sequence restart over a long train
        cfg_src_ip = 32'hC0A8_0101; cfg_dst_port = 16'hBEEF;
        run_train(64, 100, 1);
        run_train(60, 2, 0);

        finish_run();
    end
endmodule